// File: doc/BRIEF.md
# Posted Write Header and Payload Queue

This block stores posted write and message transactions that arrive from a serial link until an internal-bus master can move them on. Each transaction goes into two linked queues. A header queue keeps the bus address, the byte length and the location of the payload. A payload ring keeps the data, measured in credits of one 16-byte beat each. The ingress side offers a header. If the header is taken, the ingress side then supplies that transaction's payload beats on consecutive valid cycles. The transaction becomes visible at egress once its final beat has been written.

At egress, the oldest complete transaction is offered one beat at a time. A beat is offered only while the bus-ownership input and the ordering-permit input are both high. The transaction leaves the queues, and its credits return to the pool, only when the target has accepted its last beat. A cancel input removes the oldest transaction from both queues at once, at any point in its transfer, and leaves every younger transaction in place. Each release of credits, whether by drain or by cancel, produces a one-cycle report of how many credits came back.

Top module: `posted_txn_buffer`

## Requirements
- R1: After reset, out_valid and cred_free_valid are 0, and in_hdr_ready is 1 for any length from 1 to MAX_LEN bytes.
- R2: At most HDR_DEPTH (16) transactions are held. While 16 are held or in progress, in_hdr_ready is 0. Transactions leave egress in arrival order.
- R3: A header is accepted only when ceil(in_len/16) does not exceed the free credits. The pool holds DATA_CREDITS (240) credits, and credits are reserved at header acceptance.
- R4: While payload beats of an accepted header are still expected, in_hdr_ready is 0.
- R5: out_valid is 1 only when a complete transaction is queued and both bus_grant and order_ok are 1. out_addr and out_len carry that transaction's header values.
- R6: Beats appear in write order on out_data. The beat only advances when tgt_accept is 1 while out_valid is 1. out_last is 1 on beat ceil(len/16)-1 only.
- R7: out_be is all ones except on the last beat. On the last beat, bit k is set for k < (len mod 16), or all 16 bits are set when len mod 16 is 0.
- R8: A transaction is removed only after its last beat is accepted. In the following cycle, cred_free_valid is 1 for exactly one cycle and cred_free_cnt equals ceil(len/16).
- R9: head_err with a transaction queued removes only that transaction, including one partly transferred. It reports its credits as in R8, and the next transaction is then delivered intact.
- R10: head_err with no complete transaction queued has no effect: no credit report is produced and egress stays empty.
- R11: A header acceptance and a last-beat drain in the same cycle leave the header and credit counts exact, so exactly one more header fits afterwards.
- R12: Payload stored across the end of the 240-credit ring wraps to its start and is read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_hdr_valid | input | 1 | Ingress header offered |
| in_hdr_ready | output | 1 | Header can be taken this cycle |
| in_addr | input | ADDR_W | Bus address of the transaction |
| in_len | input | LEN_W | Payload length in bytes, 1..MAX_LEN |
| in_beat_valid | input | 1 | Payload beat present |
| in_beat_data | input | BEAT_W | Payload beat, 16 bytes |
| bus_grant | input | 1 | Master owns the internal bus |
| order_ok | input | 1 | Ordering and priority satisfied for the head |
| out_valid | output | 1 | Head beat offered to the target |
| out_addr | output | ADDR_W | Head transaction address |
| out_len | output | LEN_W | Head transaction length in bytes |
| out_data | output | BEAT_W | Current head beat |
| out_be | output | BEAT_BYTES | Byte enables of the current beat |
| out_last | output | 1 | Current beat is the final one |
| tgt_accept | input | 1 | Target takes the offered beat |
| head_err | input | 1 | Cancel the head transaction |
| cred_free_valid | output | 1 | Credit release report |
| cred_free_cnt | output | CW | Number of credits released |

## Verification
Header acceptance at ingress and release of the head at egress can fall in the same cycle. Each one changes both the header count and the credit count. The bench provokes this by queueing 15 single-beat transactions. It then raises a new header in the same cycle that the head's only beat is accepted. It judges the result at the ports: exactly one further header must be accepted, a second must be refused, and every later beat must come out in order with the right credit reports.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    function automatic int ptb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ptb_hdr_fifo.sv
module ptb_hdr_fifo #(
    parameter int W = 8,
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= din;
    end

    assign dout  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign count = st_q.cnt;

    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ptb_data_ring.sv
module ptb_data_ring #(
    parameter int DEPTH = 240,
    parameter int W = 128,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];

    assert_wr_in_ring_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(DEPTH)));
    assert_rd_in_ring_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_idx < IW'(DEPTH)));
endmodule

// File: rtl/posted_txn_buffer.sv
module posted_txn_buffer
    import ptb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BEAT_BYTES   = 16,
    parameter int MAX_LEN      = 1024,
    parameter int DATA_CREDITS = 240,
    parameter int HDR_DEPTH    = 16,
    localparam int BEAT_W = 8 * BEAT_BYTES,
    localparam int OFF_W  = $clog2(BEAT_BYTES),
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int NEED_W = LEN_W - OFF_W + 1,
    localparam int CW     = ptb_max(NEED_W, $clog2(DATA_CREDITS + 1))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_hdr_valid,
    output logic                  in_hdr_ready,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [LEN_W-1:0]      in_len,
    input  logic                  in_beat_valid,
    input  logic [BEAT_W-1:0]     in_beat_data,
    input  logic                  bus_grant,
    input  logic                  order_ok,
    output logic                  out_valid,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [LEN_W-1:0]      out_len,
    output logic [BEAT_W-1:0]     out_data,
    output logic [BEAT_BYTES-1:0] out_be,
    output logic                  out_last,
    input  logic                  tgt_accept,
    input  logic                  head_err,
    output logic                  cred_free_valid,
    output logic [CW-1:0]         cred_free_cnt
);
    localparam int IDX_W  = $clog2(DATA_CREDITS);
    localparam int HCNT_W = $clog2(HDR_DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  start;
    } hdr_t;

    localparam int HW = $bits(hdr_t);

    typedef struct packed {
        logic [CW-1:0]     beats_left;
        logic [IDX_W-1:0]  wr_ptr;
        hdr_t              cur;
        logic [HCNT_W-1:0] hdr_used;
        logic [CW-1:0]     free;
        logic [CW-1:0]     out_beat;
        logic              pulse;
        logic [CW-1:0]     pulse_cnt;
    } st_t;

    st_t st_d, st_q;

    logic              hdr_fire, beat_fire, drain_fire, flush, done;
    logic              push, fifo_empty, fifo_full, has_head, last_beat;
    logic [HW-1:0]     fifo_dout;
    logic [HCNT_W-1:0] fifo_cnt;
    hdr_t              hd;
    logic [CW-1:0]     need_in, head_beats;
    logic [LEN_W:0]    rnd_in, rnd_hd;
    logic [CW:0]       rd_sum;
    logic [IDX_W-1:0]  rd_idx;
    logic [OFF_W-1:0]  rem;

    assign rnd_in     = (LEN_W + 1)'(in_len) + (LEN_W + 1)'(BEAT_BYTES - 1);
    assign need_in    = CW'(rnd_in >> OFF_W);
    assign hd         = hdr_t'(fifo_dout);
    assign rnd_hd     = (LEN_W + 1)'(hd.len) + (LEN_W + 1)'(BEAT_BYTES - 1);
    assign head_beats = CW'(rnd_hd >> OFF_W);

    assign in_hdr_ready = (st_q.beats_left == '0)
                       && (st_q.hdr_used < HCNT_W'(HDR_DEPTH))
                       && (need_in <= st_q.free);
    assign hdr_fire  = in_hdr_valid && in_hdr_ready;
    assign beat_fire = in_beat_valid && (st_q.beats_left != '0);
    assign push      = beat_fire && (st_q.beats_left == CW'(1));

    assign has_head   = !fifo_empty;
    assign out_valid  = has_head && bus_grant && order_ok;
    assign flush      = head_err && has_head;
    assign last_beat  = (st_q.out_beat == head_beats - 1'b1);
    assign drain_fire = out_valid && tgt_accept && !flush;
    assign done       = flush || (drain_fire && last_beat);

    assign rd_sum = (CW + 1)'(hd.start) + (CW + 1)'(st_q.out_beat);
    assign rd_idx = (rd_sum >= (CW + 1)'(DATA_CREDITS))
                  ? IDX_W'(rd_sum - (CW + 1)'(DATA_CREDITS)) : IDX_W'(rd_sum);

    assign rem      = hd.len[OFF_W-1:0];
    assign out_addr = hd.addr;
    assign out_len  = hd.len;
    assign out_last = last_beat;
    assign out_be   = (!last_beat || rem == '0) ? '1
                    : (BEAT_BYTES'(1) << rem) - 1'b1;

    assign cred_free_valid = st_q.pulse;
    assign cred_free_cnt   = st_q.pulse_cnt;

    always_comb begin
        st_d = st_q;
        st_d.pulse     = done;
        st_d.pulse_cnt = done ? head_beats : '0;

        if (hdr_fire) begin
            st_d.beats_left = need_in;
            st_d.cur.addr   = in_addr;
            st_d.cur.len    = in_len;
            st_d.cur.start  = st_q.wr_ptr;
        end
        if (beat_fire) begin
            st_d.beats_left = st_q.beats_left - 1'b1;
            st_d.wr_ptr = (st_q.wr_ptr == IDX_W'(DATA_CREDITS - 1))
                        ? '0 : st_q.wr_ptr + 1'b1;
        end

        if (done)            st_d.out_beat = '0;
        else if (drain_fire) st_d.out_beat = st_q.out_beat + 1'b1;

        if (hdr_fire && !done)      st_d.hdr_used = st_q.hdr_used + 1'b1;
        else if (done && !hdr_fire) st_d.hdr_used = st_q.hdr_used - 1'b1;

        st_d.free = st_q.free - (hdr_fire ? need_in : '0)
                              + (done ? head_beats : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.free <= CW'(DATA_CREDITS);
        end else begin
            st_q <= st_d;
        end
    end

    ptb_hdr_fifo #(.W(HW), .DEPTH(HDR_DEPTH)) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (st_q.cur),
        .pop   (done),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    ptb_data_ring #(.DEPTH(DATA_CREDITS), .W(BEAT_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (beat_fire),
        .wr_idx  (st_q.wr_ptr),
        .wr_data (in_beat_data),
        .rd_en   (out_valid),
        .rd_idx  (rd_idx),
        .rd_data (out_data)
    );

    assert_hdr_count_exact_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hdr_used == fifo_cnt + HCNT_W'(st_q.beats_left != '0));
    assert_credit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.free <= CW'(DATA_CREDITS));
    assert_report_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cred_free_valid |-> (cred_free_cnt != '0));
    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !in_hdr_ready);
endmodule

// File: tb/tb_posted_txn_buffer.sv
module tb_posted_txn_buffer;
    localparam int NV = 8;
    localparam int LEN_TAB   [NV] = '{1, 15, 16, 17, 33, 100, 256, 1024};
    localparam int BEATS_TAB [NV] = '{1, 1, 1, 2, 3, 7, 16, 64};
    localparam logic [15:0] BE_TAB [NV] = '{16'h0001, 16'h7fff, 16'hffff, 16'h0001,
                                            16'h0001, 16'h000f, 16'hffff, 16'hffff};

    logic clk = 0, rst_n = 0;
    logic in_hdr_valid = 0, in_beat_valid = 0, bus_grant = 0, order_ok = 0;
    logic tgt_accept = 0, head_err = 0;
    logic [31:0] in_addr = '0;
    logic [10:0] in_len = 11'd1;
    logic [127:0] in_beat_data = '0;
    logic in_hdr_ready, out_valid, out_last, cred_free_valid;
    logic [31:0] out_addr;
    logic [10:0] out_len;
    logic [127:0] out_data;
    logic [15:0] out_be;
    logic [7:0] cred_free_cnt;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    posted_txn_buffer dut (
        .clk(clk), .rst_n(rst_n), .in_hdr_valid(in_hdr_valid), .in_hdr_ready(in_hdr_ready),
        .in_addr(in_addr), .in_len(in_len), .in_beat_valid(in_beat_valid),
        .in_beat_data(in_beat_data), .bus_grant(bus_grant), .order_ok(order_ok),
        .out_valid(out_valid), .out_addr(out_addr), .out_len(out_len), .out_data(out_data),
        .out_be(out_be), .out_last(out_last), .tgt_accept(tgt_accept), .head_err(head_err),
        .cred_free_valid(cred_free_valid), .cred_free_cnt(cred_free_cnt));

    function automatic logic [127:0] pat(input int tag, input int b);
        return {4{tag[15:0], b[15:0]}};
    endfunction

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int nbeats(input int len);
        return (len + 15) / 16;
    endfunction

    function automatic logic [15:0] last_be(input int len);
        return (len % 16 == 0) ? 16'hffff : 16'((1 << (len % 16)) - 1);
    endfunction

    // entered and left just after a falling edge
    task automatic push_beats(input int tag, input int nb);
        for (int b = 0; b < nb; b++) begin
            in_beat_valid = 1; in_beat_data = pat(tag, b);
            if (b == 0) begin
                in_len = 11'd1; #1;
                chk(in_hdr_ready, 0, "R4 header blocked during payload");
            end
            @(negedge clk);
        end
        in_beat_valid = 0;
    endtask

    task automatic push_txn(input int addr, input int len, input int tag);
        in_addr = addr; in_len = 11'(len); in_hdr_valid = 1; #1;
        chk(in_hdr_ready, 1, "R3 header accepted with room");
        @(negedge clk);
        in_hdr_valid = 0;
        push_beats(tag, nbeats(len));
    endtask

    task automatic drain_txn(input int addr, input int len, input int tag, input string req);
        int nb = nbeats(len);
        bus_grant = 1; order_ok = 1; tgt_accept = 1;
        for (int b = 0; b < nb; b++) begin
            #1;
            chk(out_valid, 1, {req, " R5 out_valid"});
            chk(out_addr, 128'(addr), {req, " R5 out_addr"});
            chk(out_len, 128'(len), {req, " R5 out_len"});
            chk(out_data, pat(tag, b), {req, " R6 out_data"});
            chk(out_last, 128'(b == nb - 1), {req, " R6 out_last"});
            chk(out_be, (b == nb - 1) ? last_be(len) : 16'hffff, {req, " R7 out_be"});
            @(negedge clk);
        end
        bus_grant = 0; order_ok = 0; tgt_accept = 0; #1;
        chk(cred_free_valid, 1, {req, " R8 credit report"});
        chk(cred_free_cnt, 128'(nb), {req, " R8 credit count"});
        @(negedge clk);
    endtask

    task automatic probe(input int len, input logic exp, input string msg);
        in_len = 11'(len); #1;
        chk(in_hdr_ready, exp, msg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        bus_grant = 1; order_ok = 1;
        probe(1024, 1, "R1 ready after reset");
        chk(out_valid, 0, "R1 out_valid after reset");
        chk(cred_free_valid, 0, "R1 no credit report after reset");
        bus_grant = 0; order_ok = 0;
        @(negedge clk);

        // vector table, three passes so the ring wraps (R12)
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < NV; i++) begin
                chk(last_be(LEN_TAB[i]), BE_TAB[i], "R7 table self-check");
                chk(nbeats(LEN_TAB[i]), BEATS_TAB[i], "R6 table self-check");
                push_txn(32'h1000 * i + p, LEN_TAB[i], p * 16 + i);
                drain_txn(32'h1000 * i + p, LEN_TAB[i], p * 16 + i, "R12 vector");
            end
        end

        // R5 gating and R6 hold
        push_txn(32'hA0, 40, 200);
        bus_grant = 1; order_ok = 0; #1;
        chk(out_valid, 0, "R5 no permit");
        bus_grant = 0; order_ok = 1; #1;
        chk(out_valid, 0, "R5 no grant");
        bus_grant = 1; tgt_accept = 0;
        repeat (2) @(negedge clk);
        #1 chk(out_data, pat(200, 0), "R6 beat held without accept");
        chk(cred_free_valid, 0, "R8 no release without accept");
        drain_txn(32'hA0, 40, 200, "R6 after hold");

        // R2 header limit and order
        for (int i = 0; i < 16; i++) push_txn(32'hB00 + i, 1, 300 + i);
        probe(1, 0, "R2 header queue full");
        for (int i = 0; i < 16; i++) drain_txn(32'hB00 + i, 1, 300 + i, "R2 order");

        // R3 credit limit
        for (int i = 0; i < 3; i++) push_txn(32'hC00 + i, 1024, 400 + i);
        probe(1024, 0, "R3 64 credits refused with 48 free");
        probe(768, 1, "R3 48 credits fit exactly");
        push_txn(32'hC03, 768, 403);
        probe(1, 0, "R3 pool exhausted");
        drain_txn(32'hC00, 1024, 400, "R3");
        probe(1024, 1, "R3 freed credits reusable");
        drain_txn(32'hC01, 1024, 401, "R3");
        drain_txn(32'hC02, 1024, 402, "R3");
        drain_txn(32'hC03, 768, 403, "R3");

        // R9 flush of idle head, then of a partly sent head
        push_txn(32'hD0, 40, 500);
        push_txn(32'hD1, 20, 501);
        head_err = 1; @(negedge clk); head_err = 0; #1;
        chk(cred_free_valid, 1, "R9 flush report");
        chk(cred_free_cnt, 3, "R9 flush credit count");
        @(negedge clk);
        drain_txn(32'hD1, 20, 501, "R9 survivor");
        push_txn(32'hD2, 48, 502);
        push_txn(32'hD3, 16, 503);
        bus_grant = 1; order_ok = 1; tgt_accept = 1;
        @(negedge clk);
        tgt_accept = 0; head_err = 1;
        @(negedge clk);
        head_err = 0; bus_grant = 0; order_ok = 0; #1;
        chk(cred_free_cnt, 3, "R9 mid-transfer flush count");
        @(negedge clk);
        drain_txn(32'hD3, 16, 503, "R9 after mid flush");

        // R10 flush on empty queue
        head_err = 1; @(negedge clk); head_err = 0; #1;
        chk(cred_free_valid, 0, "R10 no report when empty");
        bus_grant = 1; order_ok = 1; #1;
        chk(out_valid, 0, "R10 egress stays empty");
        bus_grant = 0; order_ok = 0;
        probe(1024, 1, "R10 ready unchanged");
        @(negedge clk);

        // R11 simultaneous accept and drain
        for (int i = 0; i < 15; i++) push_txn(32'hE00 + i, 16, 600 + i);
        bus_grant = 1; order_ok = 1; tgt_accept = 1;
        in_addr = 32'hEF0; in_len = 11'd16; in_hdr_valid = 1; #1;
        chk(in_hdr_ready, 1, "R11 header offered during drain");
        chk(out_last, 1, "R11 head last beat in same cycle");
        @(negedge clk);
        in_hdr_valid = 0; bus_grant = 0; order_ok = 0; tgt_accept = 0; #1;
        chk(cred_free_cnt, 1, "R11 credit report during accept");
        push_beats(700, 1);
        probe(16, 1, "R11 one slot left");
        push_txn(32'hEF1, 16, 701);
        probe(1, 0, "R11 exactly full");
        for (int i = 1; i < 15; i++) drain_txn(32'hE00 + i, 16, 600 + i, "R11 drain");
        drain_txn(32'hEF0, 16, 700, "R11 drain new");
        drain_txn(32'hEF1, 16, 701, "R11 drain last");
        probe(1024, 1, "R11 all credits back");

        finish_run();
    end
endmodule